// File: doc/BRIEF.md
# Standard Event Status Register

This block keeps the latched event flags of an instrument status model. Three kinds of event arrive as single-cycle pulses: the power-up condition, a command syntax error and an execution failure of a command that parsed cleanly. Each pulse sets its own flag. The flag stays set until software reads the register, and that read returns the flags and clears them in the same step.

An 8-bit enable mask sits next to the flags. It is written and read back on its own port. The block reports one summary bit to the status byte. That bit is high whenever a set flag lines up with a set enable bit. Command parsing, error-number queues and the other status-byte bits belong to other blocks.

Top module: `ses_status_reg`

## Requirements
- R1: After a synchronous reset the event register holds 0x80 (power flag set) and the enable register holds 0x00.
- R2: A pulse on `cmd_err_i` sets event bit 5 from the next clock edge onward.
- R3: A pulse on `exec_err_i` sets event bit 4 from the next clock edge onward.
- R4: A pulse on `pwr_evt_i` sets event bit 7 from the next clock edge onward.
- R5: Event bits 6, 3, 2, 1 and 0 always read as 0.
- R6: A set event bit stays set across any number of cycles until a read clears it.
- R7: While `evt_rd_i` is high, `evt_rdata_o` shows the event register as it stood before that edge, and the register is zero after the edge. While `evt_rd_i` is low, `evt_rdata_o` is 0x00.
- R8: If an event pulse arrives in the same cycle as a read, the returned value does not include that event, and its bit is set after the clear.
- R9: A write on `ena_wr_i` loads `ena_wdata_i` into the enable register, and `ena_o` shows the new value from the next edge. Without a write, `ena_o` holds its value. A write never changes the event bits.
- R10: `esb_o` is high in a cycle exactly when some event bit and the matching enable bit are both set in the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_evt_i | input | 1 | Power-up event pulse |
| cmd_err_i | input | 1 | Command syntax error pulse |
| exec_err_i | input | 1 | Execution error pulse |
| ena_wr_i | input | 1 | Enable register write strobe |
| ena_wdata_i | input | 8 | Enable register write data |
| evt_rd_i | input | 1 | Event register read-and-clear strobe |
| evt_rdata_o | output | 8 | Event register value returned on read, 0 otherwise |
| ena_o | output | 8 | Enable register value |
| esb_o | output | 1 | Summary bit for the status byte |

## Verification
On every cycle the assertions check four things: each event pulse sets its flag, flags stay set between reads, the read clears the register except for flags set by a coinciding pulse, and the enable register loads or holds as it should. They also check that the unused bit positions stay zero and that the summary follows the masked registers. The bench's scenarios are the only way to show three further points. The first is that the value returned in a read cycle leaves out a pulse from that same cycle. The second is the exact value that a read following several accumulated events returns. The third is that an enable write leaves the flags unchanged, which shows up in a later read.

// File: rtl/ses_pkg.sv
`timescale 1ns/1ps
package ses_pkg;

    localparam int REG_W = 8;

    localparam int PWR_POS  = 7;
    localparam int CMD_POS  = 5;
    localparam int EXEC_POS = 4;

    typedef logic [REG_W-1:0] ses_vec_t;

    typedef struct packed {
        logic pwr;
        logic cmd;
        logic exec;
    } ses_evt_t;

    function automatic ses_vec_t bit_at(input int pos);
        ses_vec_t v;
        v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

    localparam ses_vec_t IMPL_MASK = bit_at(PWR_POS) | bit_at(CMD_POS) | bit_at(EXEC_POS);
    localparam ses_vec_t EVT_RESET = bit_at(PWR_POS);
    localparam ses_vec_t ENA_RESET = '0;

    function automatic ses_vec_t evt_to_vec(input ses_evt_t e);
        ses_vec_t v;
        v = '0;
        v[PWR_POS]  = e.pwr;
        v[CMD_POS]  = e.cmd;
        v[EXEC_POS] = e.exec;
        return v & IMPL_MASK;
    endfunction

endpackage

// File: rtl/ses_evt_latch.sv
`timescale 1ns/1ps
module ses_evt_latch
    import ses_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ses_vec_t set_vec,
    input  logic     clr,
    output ses_vec_t q
);
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_impl
            logic flag_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    flag_q <= EVT_RESET[i];
                end else begin
                    flag_q <= (flag_q & ~clr) | set_vec[i];
                end
            end
            assign q[i] = flag_q;
        end else begin : g_empty
            assign q[i] = 1'b0;
        end
    end

    logic unused_set;
    assign unused_set = ^(set_vec & ~IMPL_MASK);
endmodule

// File: rtl/ses_mask_reg.sv
`timescale 1ns/1ps
module ses_mask_reg
    import ses_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  ses_vec_t wdata,
    output ses_vec_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= ENA_RESET;
        end else if (wr) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/ses_summary.sv
`timescale 1ns/1ps
module ses_summary
    import ses_pkg::*;
(
    input  ses_vec_t evt,
    input  ses_vec_t ena,
    output logic     sum
);
    ses_vec_t hit;
    for (genvar i = 0; i < REG_W; i++) begin : g_hit
        assign hit[i] = evt[i] & ena[i];
    end
    assign sum = |hit;
endmodule

// File: rtl/ses_status_reg.sv
`timescale 1ns/1ps
module ses_status_reg
    import ses_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_evt_i,
    input  logic       cmd_err_i,
    input  logic       exec_err_i,
    input  logic       ena_wr_i,
    input  logic [7:0] ena_wdata_i,
    input  logic       evt_rd_i,
    output logic [7:0] evt_rdata_o,
    output logic [7:0] ena_o,
    output logic       esb_o
);
    ses_evt_t pulses;
    ses_vec_t set_vec;
    ses_vec_t evt_q;
    ses_vec_t ena_q;

    always_comb begin
        pulses.pwr  = pwr_evt_i;
        pulses.cmd  = cmd_err_i;
        pulses.exec = exec_err_i;
        set_vec     = evt_to_vec(pulses);
    end

    ses_evt_latch u_evt (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr     (evt_rd_i),
        .q       (evt_q)
    );

    ses_mask_reg u_ena (
        .clk   (clk),
        .rst   (rst),
        .wr    (ena_wr_i),
        .wdata (ena_wdata_i),
        .q     (ena_q)
    );

    ses_summary u_sum (
        .evt (evt_q),
        .ena (ena_q),
        .sum (esb_o)
    );

    assign evt_rdata_o = evt_rd_i ? evt_q : '0;
    assign ena_o       = ena_q;
endmodule

// File: rtl/ses_status_chk.sv
`timescale 1ns/1ps
module ses_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       pwr_evt_i,
    input logic       cmd_err_i,
    input logic       exec_err_i,
    input logic       ena_wr_i,
    input logic [7:0] ena_wdata_i,
    input logic       evt_rd_i,
    input logic [7:0] evt_rdata_o,
    input logic [7:0] ena_o,
    input logic       esb_o,
    input logic [7:0] evt_q
);
    assert_cmd_sets_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_err_i |=> evt_q[5]);

    assert_exec_sets_R3: assert property (@(posedge clk) disable iff (rst)
        exec_err_i |=> evt_q[4]);

    assert_pwr_sets_R4: assert property (@(posedge clk) disable iff (rst)
        pwr_evt_i |=> evt_q[7]);

    assert_unused_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (evt_q & 8'h4F) == 8'h00);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        !evt_rd_i |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

    assert_idle_rdata_R7: assert property (@(posedge clk) disable iff (rst)
        !evt_rd_i |-> evt_rdata_o == 8'h00);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        evt_rd_i |=> evt_q == ({$past(pwr_evt_i), 1'b0, $past(cmd_err_i),
                                $past(exec_err_i), 4'b0000}));

    assert_ena_load_R9: assert property (@(posedge clk) disable iff (rst)
        ena_wr_i |=> ena_o == $past(ena_wdata_i));

    assert_ena_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !ena_wr_i |=> $stable(ena_o));

    assert_summary_R10: assert property (@(posedge clk) disable iff (rst)
        esb_o == ((evt_q & ena_o) != 8'h00));
endmodule

bind ses_status_reg ses_status_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwr_evt_i   (pwr_evt_i),
    .cmd_err_i   (cmd_err_i),
    .exec_err_i  (exec_err_i),
    .ena_wr_i    (ena_wr_i),
    .ena_wdata_i (ena_wdata_i),
    .evt_rd_i    (evt_rd_i),
    .evt_rdata_o (evt_rdata_o),
    .ena_o       (ena_o),
    .esb_o       (esb_o),
    .evt_q       (evt_q)
);

// File: tb/ses_status_reg_tb.sv
`timescale 1ns/1ps
module ses_status_reg_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_evt_i = 1'b0;
    logic       cmd_err_i = 1'b0;
    logic       exec_err_i = 1'b0;
    logic       ena_wr_i = 1'b0;
    logic [7:0] ena_wdata_i = 8'h00;
    logic       evt_rd_i = 1'b0;
    logic [7:0] evt_rdata_o;
    logic [7:0] ena_o;
    logic       esb_o;

    int    n_vec  = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    int    m_evt = 8'h80;
    int    m_ena = 0;

    always #10 clk = ~clk;

    ses_status_reg u_dut (
        .clk(clk), .rst(rst), .pwr_evt_i(pwr_evt_i), .cmd_err_i(cmd_err_i),
        .exec_err_i(exec_err_i), .ena_wr_i(ena_wr_i), .ena_wdata_i(ena_wdata_i),
        .evt_rd_i(evt_rd_i), .evt_rdata_o(evt_rdata_o), .ena_o(ena_o), .esb_o(esb_o)
    );

    // Reference model update at each active edge
    always @(posedge clk) begin
        int nxt;
        if (rst) begin
            m_evt = 8'h80;
            m_ena = 0;
        end else begin
            nxt = evt_rd_i ? 0 : m_evt;
            if (pwr_evt_i)  nxt = nxt | 8'h80;
            if (cmd_err_i)  nxt = nxt | 8'h20;
            if (exec_err_i) nxt = nxt | 8'h10;
            m_evt = nxt;
            if (ena_wr_i) m_ena = int'(ena_wdata_i);
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    // Compare every cycle, away from the edge
    task automatic compare();
        int exp_rd;
        int exp_esb;
        exp_rd  = evt_rd_i ? m_evt : 0;
        exp_esb = ((m_evt & m_ena) != 0) ? 1 : 0;
        check(evt_rd_i ? "R7" : cur_req, int'(evt_rdata_o), exp_rd, "event readout");
        check("R9", int'(ena_o), m_ena, "enable readback");
        check("R10", int'(esb_o), exp_esb, "summary bit");
        check("R5", int'(evt_rdata_o) & 8'h4F, 0, "unused bits");
    endtask

    task automatic step(input bit p, input bit c, input bit x, input bit rd,
                        input bit wr, input logic [7:0] wd);
        @(negedge clk);
        pwr_evt_i = p; cmd_err_i = c; exec_err_i = x;
        evt_rd_i = rd; ena_wr_i = wr; ena_wdata_i = wd;
        #2 compare();
    endtask

    task automatic idle(); step(0, 0, 0, 0, 0, 8'h00); endtask
    task automatic rd_expect(input string req, input int exp);
        step(0, 0, 0, 1, 0, 8'h00);
        check(req, int'(evt_rdata_o), exp, "explicit read");
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        cur_req = "R1";
        idle();
        check("R1", int'(ena_o), 0, "enable after reset");
        rd_expect("R1", 8'h80);
        rd_expect("R7", 8'h00);
        idle();
        check("R7", int'(evt_rdata_o), 0, "rdata when not reading");
        // R2
        cur_req = "R2";
        step(0, 1, 0, 0, 0, 8'h00); idle();
        rd_expect("R2", 8'h20);
        // R3
        cur_req = "R3";
        step(0, 0, 1, 0, 0, 8'h00); idle();
        rd_expect("R3", 8'h10);
        // R4
        cur_req = "R4";
        step(1, 0, 0, 0, 0, 8'h00); idle();
        rd_expect("R4", 8'h80);
        // R6: sticky across many cycles
        cur_req = "R6";
        step(0, 1, 0, 0, 0, 8'h00);
        repeat (10) idle();
        step(0, 0, 1, 0, 0, 8'h00);
        repeat (5) idle();
        rd_expect("R6", 8'h30);
        rd_expect("R6", 8'h00);
        // R8: event coinciding with read
        cur_req = "R8";
        step(0, 0, 1, 0, 0, 8'h00);
        step(0, 1, 0, 1, 0, 8'h00);
        check("R8", int'(evt_rdata_o), 8'h10, "read excludes same-cycle event");
        idle();
        rd_expect("R8", 8'h20);
        step(1, 1, 1, 1, 0, 8'h00);
        check("R8", int'(evt_rdata_o), 8'h00, "read with all pulses");
        rd_expect("R8", 8'hB0);
        // R9: enable writes, event bits untouched
        cur_req = "R9";
        step(0, 0, 1, 0, 0, 8'h00);
        step(0, 0, 0, 0, 1, 8'hFF);
        idle();
        check("R9", int'(ena_o), 8'hFF, "enable after write");
        step(0, 0, 0, 0, 1, 8'h00);
        idle();
        rd_expect("R9", 8'h10);
        // R10: summary follows mask
        cur_req = "R10";
        step(0, 0, 0, 0, 1, 8'h20);
        step(0, 0, 1, 0, 0, 8'h00);
        idle();
        check("R10", int'(esb_o), 0, "masked-out event");
        step(0, 1, 0, 0, 0, 8'h00);
        idle();
        check("R10", int'(esb_o), 1, "enabled event");
        step(0, 0, 0, 0, 1, 8'h10);
        idle();
        check("R10", int'(esb_o), 1, "mask moved to exec bit");
        rd_expect("R7", 8'h30);
        idle();
        check("R10", int'(esb_o), 0, "summary after clear");
        step(0, 0, 0, 0, 1, 8'h4F);
        step(1, 0, 0, 0, 0, 8'h00);
        idle();
        check("R10", int'(esb_o), 0, "enable on unused bits only");
        // R1 again: reset mid-run
        cur_req = "R1";
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        idle();
        check("R1", int'(ena_o), 0, "enable after second reset");
        rd_expect("R1", 8'h80);
        repeat (3) idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule